// File: doc/BRIEF.md
# Character LCD Row Refresh Serializer

This block generates the continuous refresh of a dot-matrix character panel. It walks the common rows one by one. For each row it fetches the character codes of the visible window from the display-data memory, starting at a scroll offset, and turns each code into a 5-pixel slice. The slice comes from the user glyph memory for low codes and from an external font-ROM port for all others. Cursor underline, blink and display blanking are applied to that slice before it leaves the block.

The pixel row is sent as a serial stream for a chain of column drivers. The stream carries a data bit, a shift clock, a latch strobe and an AC-inversion level, and the rightmost character goes out first. The block keeps the last 40 bits of each row in its own 40-column output register, which covers the leftmost 8 characters. A one-hot common select marks the row that is currently shown. All memory read ports are combinational: an address goes out and data comes back in the same cycle.

Top module: `lcd_refresh_scan`

## Requirements
- R1: The number of scanned rows is 8 when `twoLine`=0 and `bigFont`=0, 11 when `twoLine`=0 and `bigFont`=1, and 16 when `twoLine`=1, in which case `bigFont` is ignored. `comSel` is one-hot with bit r set for row r, and the rows are shown in ascending order, wrapping to 0.
- R2: Character position p of a row (0 is leftmost, p < NUM_CHARS) reads display address (shiftOfs+p) mod L. L is 80 in one-line mode and 40 in two-line mode. In two-line mode, rows 8..15 add 40h to that address.
- R3: In the small font, the glyph address is {code[2:0], row[2:0]} and code bit 3 has no effect. In two-line mode, rows 8..15 use row-in-line 0..7.
- R4: In the large font, the glyph address is {code[2:1], row[3:0]}, and code bits 0 and 3 have no effect.
- R5: Codes below 10h take their pixels from `cgData`. All other codes drive `romCode`=code and `romRow`=row-in-character and take `romData`. In a pattern, bit 4 is the leftmost column and 1 means the pixel is on.
- R6: With `cursorOn`, the cell whose display address equals `cursorAddr` shows all five pixels on in its bottom row. That row is 7 for the small font and 10 for the large font.
- R7: With `blinkOn`, the cursor cell alternates between all pixels on and its glyph. Each state lasts BLINK_CYCLES clocks, and the default of 102400 matches 409.6 ms at 250 kHz.
- R8: Each row sends 5×NUM_CHARS bits. The characters go from rightmost to leftmost, and within a character the order is bit 0 to bit 4. `serData` changes only while `shiftClk` is low, and each bit is valid at a rising edge of `shiftClk`.
- R9: When a row is latched, `segOut[i]` holds the pixel of character i/5, column i mod 5 (column 0 is leftmost). These are the last 40 bits that were shifted.
- R10: `latch` is high for one cycle, which follows the last `shiftClk` high cycle of the row. In the next cycle `segOut` and `comSel` show that row.
- R11: `acInv` toggles exactly when row 0 is latched, and holds its value otherwise.
- R12: With `dispOn`=0, every data bit and every segment is 0, while the row scan, `comSel` and `acInv` keep running.
- R13: During reset, `serData`, `shiftClk`, `latch`, `acInv`, `comSel` and `segOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispOn | input | 1 | Display enable |
| cursorOn | input | 1 | Cursor underline enable |
| blinkOn | input | 1 | Cursor-cell blink enable |
| twoLine | input | 1 | Two-line mode |
| bigFont | input | 1 | 5×10 font (one-line mode only) |
| shiftOfs | input | 7 | Scroll offset of the visible window |
| cursorAddr | input | 7 | Display address of the cursor |
| ddAddr | output | 7 | Display-data memory read address |
| ddData | input | 8 | Character code read back |
| cgAddr | output | 6 | User glyph memory read address |
| cgData | input | 5 | User glyph pixel bits |
| romCode | output | 8 | Character code to the font ROM port |
| romRow | output | 4 | Row within the character to the font ROM port |
| romData | input | 5 | Font ROM pixel bits |
| serData | output | 1 | Serial pixel data to the driver chain |
| shiftClk | output | 1 | Shift clock, data valid at its rising edge |
| latch | output | 1 | Row latch strobe |
| acInv | output | 1 | AC inversion level |
| comSel | output | 16 | One-hot common row select |
| segOut | output | 40 | On-chip segment columns |

## Verification
The checks assume three things about the inputs. The memories answer within the same cycle, `shiftOfs` stays below the active line length, and the mode inputs are quasi-static: a change may corrupt at most the row in flight. The handshake checks (latch after the final shift-clock high, data stable at the shift-clock rise, acInv moving only after a latch) hold for any input sequence. The blanking check only relies on `dispOn` being sampled with the pixel. The stimulus changes the configuration only while no comparison is pending, then compares only rows that were shifted entirely under the new setting. It keeps the scroll offset inside 0..39 in two-line mode and inside 0..79 in one-line mode.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int CHAR_IDX_W = 6;
  localparam int ROW_W      = 4;
  localparam int PIX_W      = 5;

  typedef struct packed {
    logic                  loadBit;
    logic                  shiftBit;
    logic                  latchRow;
    logic [ROW_W-1:0]      rowIdx;
    logic [CHAR_IDX_W-1:0] charIdx;
    logic [2:0]            bitIdx;
    logic                  blinkPhase;
  } scanStrobe_t;

  typedef enum logic [1:0] {ST_LO, ST_HI, ST_LATCH, ST_SWAP} scanState_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_CHARS    = 16,
  parameter int BLINK_CYCLES = 102400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        twoLine,
  input  logic        bigFont,
  output scanStrobe_t strb,
  output logic        shiftClk,
  output logic        latch,
  output logic        acInv,
  output logic [15:0] comSel
);
  localparam int BLINK_W = $clog2(BLINK_CYCLES + 1);
  localparam logic [CHAR_IDX_W-1:0] LAST_CHAR = CHAR_IDX_W'(NUM_CHARS - 1);

  scanState_t            state;
  logic [ROW_W-1:0]      rowIdx;
  logic [CHAR_IDX_W-1:0] charIdx;
  logic [2:0]            bitIdx;
  logic [BLINK_W-1:0]    blinkCnt;
  logic                  blinkPhase;
  logic [ROW_W:0]        rowsNow;
  logic [ROW_W:0]        rowPlus;

  always_comb begin
    rowsNow = twoLine ? 5'd16 : (bigFont ? 5'd11 : 5'd8);
    rowPlus = {1'b0, rowIdx} + 5'd1;
  end

  always_comb begin
    strb.loadBit    = (state == ST_LO);
    strb.shiftBit   = (state == ST_HI);
    strb.latchRow   = (state == ST_SWAP);
    strb.rowIdx     = rowIdx;
    strb.charIdx    = charIdx;
    strb.bitIdx     = bitIdx;
    strb.blinkPhase = blinkPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else if (blinkCnt == BLINK_W'(BLINK_CYCLES - 1)) begin
      blinkCnt   <= '0;
      blinkPhase <= ~blinkPhase;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LO;
      rowIdx   <= '0;
      charIdx  <= LAST_CHAR;
      bitIdx   <= '0;
      shiftClk <= 1'b0;
      latch    <= 1'b0;
      acInv    <= 1'b0;
      comSel   <= '0;
    end else begin
      case (state)
        ST_LO: begin
          shiftClk <= 1'b0;
          state    <= ST_HI;
        end
        ST_HI: begin
          shiftClk <= 1'b1;
          if (bitIdx == 3'd4) begin
            bitIdx <= '0;
            if (charIdx == '0) begin
              charIdx <= LAST_CHAR;
              state   <= ST_LATCH;
            end else begin
              charIdx <= charIdx - 1'b1;
              state   <= ST_LO;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
            state  <= ST_LO;
          end
        end
        ST_LATCH: begin
          shiftClk <= 1'b0;
          latch    <= 1'b1;
          state    <= ST_SWAP;
        end
        default: begin
          latch  <= 1'b0;
          comSel <= 16'(1) << rowIdx;
          if (rowIdx == '0) acInv <= ~acInv;
          rowIdx <= (rowPlus >= rowsNow) ? '0 : rowPlus[ROW_W-1:0];
          state  <= ST_LO;
        end
      endcase
    end
  end

  assert_comsel_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comSel));
  assert_latch_after_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    latch |-> $past(shiftClk));
  assert_clk_low_at_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    latch |-> !shiftClk);
  assert_ac_moves_after_latch_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(latch) |-> $stable(acInv));
endmodule

// File: rtl/lcd_scan_dpath.sv
module lcd_scan_dpath
  import lcd_scan_pkg::*;
#(
  parameter int SEG_CHARS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scanStrobe_t            strb,
  input  logic                   dispOn,
  input  logic                   cursorOn,
  input  logic                   blinkOn,
  input  logic                   twoLine,
  input  logic                   bigFont,
  input  logic [6:0]             shiftOfs,
  input  logic [6:0]             cursorAddr,
  output logic [6:0]             ddAddr,
  input  logic [7:0]             ddData,
  output logic [5:0]             cgAddr,
  input  logic [PIX_W-1:0]       cgData,
  output logic [7:0]             romCode,
  output logic [ROW_W-1:0]       romRow,
  input  logic [PIX_W-1:0]       romData,
  output logic                   serData,
  output logic [5*SEG_CHARS-1:0] segOut
);
  localparam int SEG_BITS = 5 * SEG_CHARS;

  logic             bigEff, lineSel, useCg, atCursor, pixel;
  logic [ROW_W-1:0] charRow, cursorRow;
  logic [7:0]       lineLen, posSum, posWrap;
  logic [PIX_W-1:0] glyph, pat;
  logic [SEG_BITS-1:0] shiftReg;

  always_comb begin
    bigEff    = bigFont & ~twoLine;
    lineSel   = twoLine & strb.rowIdx[3];
    charRow   = twoLine ? {1'b0, strb.rowIdx[2:0]} : strb.rowIdx;
    lineLen   = twoLine ? 8'd40 : 8'd80;
    posSum    = {1'b0, shiftOfs} + {2'b00, strb.charIdx};
    posWrap   = (posSum >= lineLen) ? posSum - lineLen : posSum;
    ddAddr    = posWrap[6:0] + (lineSel ? 7'h40 : 7'h00);
    useCg     = (ddData[7:4] == 4'h0);
    cgAddr    = bigEff ? {ddData[2:1], charRow} : {ddData[2:0], charRow[2:0]};
    romCode   = ddData;
    romRow    = charRow;
    glyph     = useCg ? cgData : romData;
    cursorRow = bigEff ? 4'd10 : 4'd7;
    atCursor  = (ddAddr == cursorAddr);
    pat       = glyph;
    if (cursorOn && atCursor && (charRow == cursorRow)) pat = '1;
    if (blinkOn && atCursor && strb.blinkPhase) pat = '1;
    if (!dispOn) pat = '0;
    pixel     = pat[strb.bitIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serData  <= 1'b0;
      shiftReg <= '0;
      segOut   <= '0;
    end else begin
      if (strb.loadBit)  serData  <= pixel;
      if (strb.shiftBit) shiftReg <= {shiftReg[SEG_BITS-2:0], serData};
      if (strb.latchRow) segOut   <= shiftReg;
    end
  end

  assert_dark_data_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadBit && !dispOn) |=> !serData);
endmodule

// File: rtl/lcd_refresh_scan.sv
module lcd_refresh_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_CHARS    = 16,
  parameter int SEG_CHARS    = 8,
  parameter int BLINK_CYCLES = 102400
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dispOn,
  input  logic                   cursorOn,
  input  logic                   blinkOn,
  input  logic                   twoLine,
  input  logic                   bigFont,
  input  logic [6:0]             shiftOfs,
  input  logic [6:0]             cursorAddr,
  output logic [6:0]             ddAddr,
  input  logic [7:0]             ddData,
  output logic [5:0]             cgAddr,
  input  logic [4:0]             cgData,
  output logic [7:0]             romCode,
  output logic [3:0]             romRow,
  input  logic [4:0]             romData,
  output logic                   serData,
  output logic                   shiftClk,
  output logic                   latch,
  output logic                   acInv,
  output logic [15:0]            comSel,
  output logic [5*SEG_CHARS-1:0] segOut
);
  scanStrobe_t strb;

  lcd_scan_ctrl #(.NUM_CHARS(NUM_CHARS), .BLINK_CYCLES(BLINK_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .twoLine(twoLine), .bigFont(bigFont), .strb(strb),
    .shiftClk(shiftClk), .latch(latch), .acInv(acInv), .comSel(comSel));

  lcd_scan_dpath #(.SEG_CHARS(SEG_CHARS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .dispOn(dispOn), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .twoLine(twoLine), .bigFont(bigFont), .shiftOfs(shiftOfs),
    .cursorAddr(cursorAddr), .ddAddr(ddAddr), .ddData(ddData), .cgAddr(cgAddr),
    .cgData(cgData), .romCode(romCode), .romRow(romRow), .romData(romData),
    .serData(serData), .segOut(segOut));

  assert_data_steady_at_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> $stable(serData));
endmodule

// File: tb/sim_lcd_refresh_scan.sv
module sim_lcd_refresh_scan;
  localparam int NCH   = 16;
  localparam int SBITS = 5 * NCH;
  localparam int SEGW  = 40;
  localparam int BLINK = 4000;
  localparam int LIMIT = 190000;

  logic clk = 1'b0, rstN = 1'b0;
  logic dispOn = 0, cursorOn = 0, blinkOn = 0, twoLine = 0, bigFont = 0;
  logic [6:0] shiftOfs = 0, cursorAddr = 7'h7f;
  logic [6:0] ddAddr; logic [7:0] ddData; logic [5:0] cgAddr; logic [4:0] cgData;
  logic [7:0] romCode; logic [3:0] romRow; logic [4:0] romData;
  logic serData, shiftClk, latch, acInv;
  logic [15:0] comSel; logic [SEGW-1:0] segOut;

  logic [7:0] dd [0:127];
  logic [7:0] cg [0:63];

  typedef struct {
    int row; logic [SBITS-1:0] stream, smask; logic [SEGW-1:0] seg, gmask; string req;
  } expRow_t;
  expRow_t q[$];

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  function automatic logic [4:0] romFn(logic [7:0] c, logic [3:0] r);
    return 5'(c ^ (8'(r) * 8'd5));
  endfunction

  assign ddData  = dd[ddAddr];
  assign cgData  = cg[cgAddr][4:0];
  assign romData = romFn(romCode, romRow);

  lcd_refresh_scan #(.NUM_CHARS(NCH), .SEG_CHARS(8), .BLINK_CYCLES(BLINK)) u0 (
    .clk(clk), .rstN(rstN), .dispOn(dispOn), .cursorOn(cursorOn), .blinkOn(blinkOn),
    .twoLine(twoLine), .bigFont(bigFont), .shiftOfs(shiftOfs), .cursorAddr(cursorAddr),
    .ddAddr(ddAddr), .ddData(ddData), .cgAddr(cgAddr), .cgData(cgData),
    .romCode(romCode), .romRow(romRow), .romData(romData), .serData(serData),
    .shiftClk(shiftClk), .latch(latch), .acInv(acInv), .comSel(comSel), .segOut(segOut));

  task automatic check(bit ok, string msg, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  function automatic logic [4:0] cellPat(int row, int p, output logic blinkCell);
    int line, crow, len, a; logic big; logic [7:0] code; logic [5:0] idx; logic [4:0] g;
    big  = bigFont & ~twoLine;
    line = twoLine ? row / 8 : 0;
    crow = twoLine ? row % 8 : row;
    len  = twoLine ? 40 : 80;
    a    = (int'(shiftOfs) + p) % len + (line != 0 ? 64 : 0);
    code = dd[a];
    if (code < 8'h10) begin
      idx = big ? {code[2:1], 4'(crow)} : {code[2:0], 3'(crow)};
      g = cg[idx][4:0];
    end else g = romFn(code, 4'(crow));
    if (cursorOn && a == int'(cursorAddr) && crow == (big ? 10 : 7)) g = 5'h1f;
    blinkCell = blinkOn && a == int'(cursorAddr);
    if (!dispOn) begin g = 0; blinkCell = 0; end
    return g;
  endfunction

  function automatic expRow_t makeRow(int row, string req);
    expRow_t e; logic [4:0] pat [NCH]; logic bl [NCH];
    e.row = row; e.req = req;
    for (int p = 0; p < NCH; p++) pat[p] = cellPat(row, p, bl[p]);
    for (int j = 0; j < SBITS; j++) begin
      e.stream[j] = pat[NCH-1-j/5][j%5];
      e.smask[j]  = bl[NCH-1-j/5];
    end
    for (int i = 0; i < SEGW; i++) begin
      e.seg[i]   = pat[i/5][4-i%5];
      e.gmask[i] = bl[i/5];
    end
    return e;
  endfunction

  // Monitor: collects the serial stream and compares at each latched row
  logic [SBITS-1:0] got; int bitCount = 0; logic prevSc = 0, prevLatch = 0, acPrev = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (shiftClk && !prevSc) begin
        if (bitCount < SBITS) got[bitCount] = serData;
        bitCount++;
      end
      if (latch && !prevLatch)
        check(bitCount == SBITS, "R10 latch after last shift edge", 128'(bitCount), 128'(SBITS));
      if (prevLatch && !latch) begin
        check(acInv == (comSel == 16'h1 ? ~acPrev : acPrev), "R11 acInv at frame start",
              128'(acInv), 128'(comSel == 16'h1 ? ~acPrev : acPrev));
        acPrev = acInv;
        if (q.size() != 0) begin
          expRow_t e; logic [SBITS-1:0] sm; logic [SEGW-1:0] gm;
          e = q.pop_front();
          check(comSel == 16'(1) << e.row, "R1 comSel row", 128'(comSel), 128'(16'(1) << e.row));
          sm = (got ^ e.stream) & ~(e.smask & ~e.stream);
          check(sm == 0, {e.req, " R8 serial stream"}, 128'(got), 128'(e.stream));
          gm = (segOut ^ e.seg) & ~(e.gmask & ~e.seg);
          check(gm == 0, {e.req, " R9 segOut"}, 128'(segOut), 128'(e.seg));
        end
        got = '0; bitCount = 0;
      end
    end
    prevSc = shiftClk; prevLatch = latch;
  end

  task automatic waitDrain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // Driver: pushes expected rows that will be shifted wholly under the current settings
  task automatic runCase(string req, int nrows);
    int r, rows, nxt;
    waitDrain();
    do @(negedge clk); while (latch !== 1'b1);
    @(posedge clk); @(posedge clk); #1;
    r = 0;
    for (int i = 0; i < 16; i++) if (comSel[i]) r = i;
    rows = twoLine ? 16 : (bigFont ? 11 : 8);
    nxt = (r + 1 >= rows) ? 0 : r + 1;
    for (int k = 0; k < nrows; k++) q.push_back(makeRow((nxt + k) % rows, req));
    waitDrain();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int sawOn, sawGlyph;
    for (int a = 0; a < 128; a++) dd[a] = (a % 3 == 0) ? 8'(a % 16) : 8'(8'h30 + a);
    for (int i = 0; i < 64; i++) cg[i] = {3'b101, 5'(i * 7 + 3)};
    dd[6] = 8'h0a; dd[9] = 8'h02;   // code bit 3 must not matter (R3)
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({serData, shiftClk, latch, acInv} == 0, "R13 reset controls", 128'({serData, shiftClk, latch, acInv}), 0);
    check(comSel == 0 && segOut == 0, "R13 reset comSel/segOut", 128'({comSel, segOut}), 0);
    rstN = 1'b1;
    dispOn = 1;

    runCase("R5", 9);                          // small font, one line, ROM and glyph RAM codes
    runCase("R3", 8);
    shiftOfs = 7'd75; runCase("R2", 8);        // window wraps past 79
    shiftOfs = 0; cursorOn = 1; cursorAddr = 7'd3;
    runCase("R6", 8);
    bigFont = 1; dd[4] = 8'h03; dd[2] = 8'h0e; // 5x10: code bits 0 and 3 ignored (R4)
    runCase("R4", 12);
    twoLine = 1; shiftOfs = 7'd35; cursorAddr = 7'h42;
    runCase("R2", 17);                         // two lines, bigFont ignored (R1)
    twoLine = 0; bigFont = 0; shiftOfs = 0; cursorOn = 0; dispOn = 0;
    runCase("R12", 9);
    dispOn = 1; blinkOn = 1; cursorAddr = 7'd1;
    runCase("R7", 8);
    sawOn = 0; sawGlyph = 0;
    for (int c = 0; c < 3 * BLINK; c++) begin
      @(negedge clk);
      if (segOut[9:5] == 5'h1f) sawOn++; else sawGlyph++;
    end
    check(sawOn > 0 && sawGlyph > 0, "R7 blink alternates", 128'({sawOn, sawGlyph}), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule